// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an asynchronous static RAM of 64K words by 16 bits. The RAM has separate active-low enables for its low and high byte. The host presents one request at a time through a valid/ready handshake. Each request carries a word address, a direction, write data and a two-bit lane mask. The controller then plays the strobe sequence the RAM needs, timed in whole clock cycles set by parameters. Reads come back as a one-cycle result pulse, with any lane the mask leaves out forced to zero.

Every strobe, the address and the lane enables leave the block from registers, so the RAM never sees a glitch from decode logic. The controller drives the data bus only while output enable is high. It asserts write enable in the same cycle as its bus driver, and it keeps driving for one cycle after write enable rises, so the data is still valid at the edge where the RAM captures it. Between transactions chip enable returns high, which puts the RAM into standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no transaction is in progress, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, `sram_be_n` is 2'b11, `sram_dq_oe` is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for WP_CYC+2 cycles for a write (4 with the defaults) and for max(ACC_CYC, OE_CYC) cycles for a read (2 with the defaults).
- R3: In a write, one address setup cycle comes first. `sram_we_n` is then low for exactly WP_CYC cycles, and `sram_oe_n` stays high throughout. `sram_dq_oe` is high from the first low cycle of `sram_we_n` through the one cycle after it rises, and `sram_dq_out` equals the request's write data in all of those cycles.
- R4: Mask bit 0 selects the low lane (data bits 7:0, `sram_be_n[0]`) and mask bit 1 selects the high lane (bits 15:8, `sram_be_n[1]`). While `sram_ce_n` is low, `sram_be_n` equals the inverted mask. A lane left out of a write keeps its stored value, and a mask of 2'b00 changes no memory content.
- R5: In a read, `sram_ce_n` and `sram_oe_n` are low and `sram_we_n` is high for max(ACC_CYC, OE_CYC) cycles. The bus is sampled at the end of the last of those cycles, and `rd_valid` is high for exactly one cycle, the cycle in which `req_ready` returns high.
- R6: `rd_data` holds the stored word on the selected lanes and zero on every lane the mask leaves out.
- R7: `sram_dq_oe` is never high while the RAM could be driving the bus, that is, never while `sram_oe_n` is low.
- R8: `sram_addr` and `sram_be_n` do not change during a cycle in which `sram_ce_n` is low and was also low in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read result, zero on lanes not selected |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_be_n | output | 2 | RAM lane enables, bit 0 low byte, active low |
| sram_addr | output | 16 | RAM address |
| sram_dq_out | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Bus driver enable for sram_dq_out |
| sram_dq_in | input | 16 | Data read from the bus |

## Verification
The assertions check the bus-ownership rule on every cycle, and so do the idle standby state, the driver enable covering write enable and the write-enable rising edge, the stability of the address and lane enables while chip enable is held low, and the single-cycle result pulse. Only the bench scenarios can show the rest, and they do so through a behavioural RAM model with a read-access delay. These cover lane-selective writes leaving the other byte untouched, zeroed lanes on masked reads, sampling after the access time rather than before, and the busy length of each transaction. They also check that back-to-back mixed traffic matches a reference array.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC
  } seq_st_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic lanes_on;
    logic drive;
  } strobe_t;

  // Strobe levels for each sequencer state; registered by the sequencer.
  function automatic strobe_t strobe_of(seq_st_t s);
    strobe_t r;
    r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
    case (s)
      ST_WSETUP: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b1, drive: 1'b0};
      ST_WPULSE: r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, lanes_on: 1'b1, drive: 1'b1};
      ST_WHOLD:  r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b1, drive: 1'b1};
      ST_RACC:   r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, lanes_on: 1'b1, drive: 1'b0};
      default:   r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int WP_CYC = 2,
  parameter int RD_CYC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  output logic    req_ready,
  output logic    accept,
  output logic    capture,
  output strobe_t strb_d,
  output strobe_t strb_q
);

  localparam int MAXC = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WP_LAST = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);

  seq_st_t        state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = req_write ? ST_WSETUP : ST_RACC;
          cnt_d   = req_write ? '0 : RD_LAST;
        end
      end
      ST_WSETUP: begin
        state_d = ST_WPULSE;
        cnt_d   = WP_LAST;
      end
      ST_WPULSE: begin
        if (cnt_q == '0) state_d = ST_WHOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WHOLD: state_d = ST_IDLE;
      ST_RACC: begin
        if (cnt_q == '0) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign strb_d = strobe_of(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      strb_q  <= strobe_of(ST_IDLE);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      strb_q  <= strb_d;
    end
  end

endmodule

// File: rtl/sram_lane_dpath.sv
module sram_lane_dpath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              lanes_on_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic [LANES-1:0]  sram_be_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdat_q, lane_keep;
  logic [LANES-1:0]  mask_q, mask_d, be_n_q, be_n_d;
  logic              rdv_q;

  assign mask_d = accept ? req_mask : mask_q;
  assign be_n_d = ~(lanes_on_d ? mask_d : '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_keep[g*LANE_W +: LANE_W] = {LANE_W{mask_q[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_n_q <= '1;
      rdv_q  <= 1'b0;
    end else begin
      be_n_q <= be_n_d;
      rdv_q  <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (capture) rdat_q <= sram_dq_in & lane_keep;
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign sram_be_n   = be_n_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdat_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int ACC_CYC = 2,
  parameter int OE_CYC  = 1,
  parameter int WP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_be_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int RD_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;

  logic    accept, capture;
  strobe_t strb_d, strb_q;

  sram_lane_seq #(.WP_CYC(WP_CYC), .RD_CYC(RD_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .strb_d    (strb_d),
    .strb_q    (strb_q)
  );

  sram_lane_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .capture     (capture),
    .lanes_on_d  (strb_d.lanes_on),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_mask    (req_mask),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_be_n   (sram_be_n),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  assign sram_ce_n  = strb_q.ce_n;
  assign sram_we_n  = strb_q.we_n;
  assign sram_oe_n  = strb_q.oe_n;
  assign sram_dq_oe = strb_q.drive;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [LANES-1:0]  sram_be_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_dq_oe
);

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && (&sram_be_n)));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_we_with_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_dq_oe && sram_oe_n));

  assert_data_at_we_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $rose(sram_we_n)) |-> sram_dq_oe);

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_rd_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ready);

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_be_n)));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_be_n  (sram_be_n),
  .sram_addr  (sram_addr),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;

  localparam int ACC = 2;
  localparam int OEC = 1;
  localparam int WP  = 2;
  localparam int RDC = (ACC > OEC) ? ACC : OEC;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_mask;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_addr, sram_dq_out, sram_dq_in;

  int errors = 0;
  int checks = 0;
  int clashes = 0;
  int age = 0;

  logic [15:0] model_mem [int];
  logic [15:0] ref_mem   [int];
  logic [15:0] exp_q     [$];

  sram_lane_ctrl #(.ACC_CYC(ACC), .OE_CYC(OEC), .WP_CYC(WP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_be_n(sram_be_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural RAM: drives only when enabled for read, data valid after ACC cycles.
  logic mem_drive;
  logic [15:0] mem_word;
  assign mem_drive = !sram_ce_n && !sram_oe_n && sram_we_n && (sram_be_n != 2'b11);

  always_comb begin
    mem_word = model_mem.exists(int'(sram_addr)) ? model_mem[int'(sram_addr)] : 16'h0000;
    if (sram_dq_oe)
      sram_dq_in = sram_dq_out;
    else if (mem_drive && age >= ACC)
      sram_dq_in = {sram_be_n[1] ? 8'h5A : mem_word[15:8], sram_be_n[0] ? 8'hC3 : mem_word[7:0]};
    else if (mem_drive)
      sram_dq_in = 16'h9999;
    else
      sram_dq_in = 16'hC35A;
  end

  always @(negedge clk) begin
    if (!mem_drive) age <= 0;
    else if (age < 7) age <= age + 1;
    if (rst_n && sram_dq_oe && mem_drive) clashes <= clashes + 1;
  end

  always @(posedge sram_we_n) begin
    if (sram_ce_n === 1'b0) begin
      logic [15:0] w;
      w = model_mem.exists(int'(sram_addr)) ? model_mem[int'(sram_addr)] : 16'h0000;
      if (!sram_be_n[0]) w[7:0]  = sram_dq_out[7:0];
      if (!sram_be_n[1]) w[15:8] = sram_dq_out[15:8];
      model_mem[int'(sram_addr)] = w;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Scoreboard monitor: pops expected read results.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected rd_valid", 32'(rd_data), 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R6 read data", 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    int busy, we_lo, drv;
    bit oe_ok, be_ok, ad_ok, dat_ok;
    logic [15:0] w;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
    busy = 0; we_lo = 0; drv = 0; oe_ok = 1; be_ok = 1; ad_ok = 1; dat_ok = 1;
    while (!req_ready && busy < 50) begin
      busy++;
      if (!sram_we_n) we_lo++;
      if (sram_dq_oe) begin
        drv++;
        if (sram_dq_out != d) dat_ok = 0;
      end
      if (!sram_oe_n) oe_ok = 0;
      if (sram_be_n != ~m) be_ok = 0;
      if (sram_addr != a) ad_ok = 0;
      @(negedge clk);
    end
    chk(busy == WP + 2, "R2 write busy cycles", 32'(busy), 32'(WP + 2));
    chk(we_lo == WP, "R3 we_n low cycles", 32'(we_lo), 32'(WP));
    chk(drv == WP + 1, "R3 driver cycles", 32'(drv), 32'(WP + 1));
    chk(dat_ok && oe_ok, "R3 data and oe_n during write", {30'h0, dat_ok, oe_ok}, 32'h3);
    chk(be_ok, "R4 lane enables during write", 32'(sram_be_n), 32'(~m));
    chk(ad_ok, "R8 address during write", 32'(ad_ok), 32'h1);
    w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    w = (w & ~lane_mask(m)) | (d & lane_mask(m));
    ref_mem[int'(a)] = w;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] m);
    int busy;
    bit rd_ok, be_ok, ad_ok;
    logic [15:0] w;
    w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    exp_q.push_back(w & lane_mask(m));
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 16'h0; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_mask = ~m;
    busy = 0; rd_ok = 1; be_ok = 1; ad_ok = 1;
    while (!req_ready && busy < 50) begin
      busy++;
      if (sram_ce_n || sram_oe_n || !sram_we_n || sram_dq_oe) rd_ok = 0;
      if (sram_be_n != ~m) be_ok = 0;
      if (sram_addr != a) ad_ok = 0;
      @(negedge clk);
    end
    chk(busy == RDC, "R2 read busy cycles", 32'(busy), 32'(RDC));
    chk(rd_ok, "R5 read strobes", 32'(rd_ok), 32'h1);
    chk(rd_valid, "R5 rd_valid with ready", 32'(rd_valid), 32'h1);
    chk(be_ok, "R4 lane enables during read", 32'(sram_be_n), 32'(~m));
    chk(ad_ok, "R8 address during read", 32'(ad_ok), 32'h1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    report();
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 strobes in reset",
        {28'h0, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 32'hE);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_valid && sram_be_n == 2'b11, "R1 idle after reset",
        {29'h0, req_ready, rd_valid, &sram_be_n}, 32'h5);

    // Full-word traffic, address extremes.
    do_write(16'h0000, 16'h1234, 2'b11);
    do_write(16'hFFFF, 16'hBEEF, 2'b11);
    do_read (16'h0000, 2'b11);
    do_read (16'hFFFF, 2'b11);
    chk(sram_ce_n && !sram_dq_oe, "R1 standby between requests",
        {30'h0, sram_ce_n, sram_dq_oe}, 32'h2);

    // R4: lane-selective writes leave the other byte alone.
    do_write(16'h0000, 16'hAA55, 2'b01);
    do_read (16'h0000, 2'b11);
    do_write(16'h0000, 16'h77CC, 2'b10);
    do_read (16'h0000, 2'b11);
    do_write(16'hFFFF, 16'h0000, 2'b00);
    do_read (16'hFFFF, 2'b11);

    // R6: masked reads return zero on unselected lanes.
    do_read (16'hFFFF, 2'b01);
    do_read (16'hFFFF, 2'b10);
    do_read (16'h0000, 2'b00);
    do_read (16'h1357, 2'b11);

    // Back-to-back mixed traffic.
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3]) do_write({8'h40, 4'h0, lfsr[11:8]}, lfsr[31:16], lfsr[5:4]);
      else         do_read ({8'h40, 4'h0, lfsr[11:8]}, lfsr[5:4]);
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads returned", 32'(exp_q.size()), 32'h0);
    chk(clashes == 0, "R7 bus contention cycles", 32'(clashes), 32'h0);
    report();
  end

endmodule